// File: doc/BRIEF.md
# DMA Transfer Address Sequencer

This block produces the address phase of each transfer made by a DMA engine. The low address byte goes straight out on dedicated address pins. The high address byte is placed on the shared data bus for a single clock, and an active-high strobe makes an external transparent latch capture it. While a service is in progress, an address-enable output keeps that latch and the dedicated pins on the system bus.

A separate transfer engine supplies one address per transfer over a valid/ready handshake, and holds a service flag high for as long as it owns the bus. The first transfer of each service always reloads the external latch. After that, the latch is reloaded only when the high byte of the new address differs from the byte last latched. Runs of transfers inside one 256-byte page therefore take one clock each, with no update clock between them.

Back-pressure rules: a step is taken on a rising clock edge where `step_valid` and `step_ready` are both high. The engine must hold `step_valid` and `step_addr` until that edge. `step_ready` is low whenever the service flag is low, and also during the clock in which the high byte is on the data bus.

Top module: `dma_addr_seq`

## Requirements
- R1: While reset is asserted, `aen`, `a_oe`, `adstb`, `db_oe` and `xfer_go` are all 0, and `a_out` is 0.
- R2: `aen` and `a_oe` are equal. Both are 1 in the clock after a clock in which `svc_active` was 1, and both are 0 in the clock after a clock in which it was 0. In that released clock, `adstb`, `db_oe` and `xfer_go` are also 0.
- R3: The first step accepted in a service gives one update clock on the next edge. In that clock `adstb` = 1, `db_oe` = 1, `db_out` = `step_addr[15:8]` and `a_out` = `step_addr[7:0]`. The clock after it has `xfer_go` = 1, `adstb` = 0 and `a_out` unchanged.
- R4: A later step in the same service whose bits [15:8] equal the last latched high byte gives, on the next edge, `xfer_go` = 1, `adstb` = 0, `db_oe` = 0 and `a_out` = `step_addr[7:0]`.
- R5: A later step whose bits [15:8] differ from the last latched high byte gives an update clock and then a transfer clock, exactly as in R3, carrying the new high byte.
- R6: `step_ready` is 0 when `svc_active` is 0 and during an update clock. A `step_valid` offered then is not taken: no update is started for it and `a_out` does not change.
- R7: In a clock after an edge where no step was taken and no update was pending, `xfer_go` and `adstb` are 0 and `a_out` keeps the last low byte.
- R8: A step whose high byte matches the byte latched in an earlier service still gives an update clock when it is the first step after `svc_active` has been 0.
- R9: `db_oe` is 1 only in update clocks, together with `adstb`. An update clock lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| svc_active | input | 1 | High while the DMA service owns the bus |
| step_valid | input | 1 | A transfer address is offered |
| step_ready | output | 1 | The sequencer can take the offered address this clock |
| step_addr | input | 16 | Transfer address |
| aen | output | 1 | Address enable for the external high-byte latch |
| a_oe | output | 1 | Drive enable for the low address pins |
| a_out | output | 8 | Low address byte |
| adstb | output | 1 | Strobe for the external high-byte latch |
| db_oe | output | 1 | Drive enable for the data bus |
| db_out | output | 8 | High address byte for the data bus |
| xfer_go | output | 1 | Marks the clock in which the transfer's address is complete |

## Verification
All outputs are registered. Every result of a step, or of a change of `svc_active`, is due on the first rising edge after the inputs were driven. The transfer clock that follows an update is due one edge later. The bench applies inputs on the falling edge and checks `step_ready` 1 ns later, since `step_ready` is combinational. For each clock it queues the expected output set, and compares it 2 ns after the next rising edge. The update and transfer clocks therefore each land in their own slot of the queue.

// File: rtl/dma_addr_seq_pkg.sv
package dma_addr_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_UPD  = 2'd2,
    PH_XFER = 2'd3
  } phase_t;
endpackage

// File: rtl/dma_hi_track.sv
module dma_hi_track #(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            svc_active,
  input  logic            take,
  input  logic [HI_W-1:0] hi_in,
  output logic [HI_W-1:0] hi_q,
  output logic            need_upd
);
  logic latched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched <= 1'b0;
      hi_q    <= '0;
    end else if (!svc_active) begin
      latched <= 1'b0;
    end else if (take) begin
      latched <= 1'b1;
      hi_q    <= hi_in;
    end
  end

  assign need_upd = !latched || (hi_in != hi_q);

  // R8: once the service flag has been low, the first new step must reload the latch
  a_r8_fresh_service: assert property (@(posedge clk) disable iff (!rst_n)
    !svc_active |=> need_upd);
endmodule

// File: rtl/dma_phase_ctl.sv
module dma_phase_ctl
  import dma_addr_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   svc_active,
  input  logic   take,
  input  logic   need_upd,
  output phase_t phase
);
  phase_t phase_nx;

  always_comb begin
    if (!svc_active)           phase_nx = PH_IDLE;
    else if (phase == PH_UPD)  phase_nx = PH_XFER;
    else if (take)             phase_nx = need_upd ? PH_UPD : PH_XFER;
    else                       phase_nx = PH_WAIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end

  // R9: an update clock never repeats
  a_r9_upd_single: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_UPD) |=> (phase != PH_UPD));
  // R3: an update with the service still on is followed by the transfer clock
  a_r3_upd_then_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_UPD && svc_active) |=> (phase == PH_XFER));
endmodule

// File: rtl/dma_pin_drive.sv
module dma_pin_drive
  import dma_addr_seq_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            svc_active,
  input  logic            take,
  input  logic [LO_W-1:0] lo_in,
  input  phase_t          phase,
  input  logic [HI_W-1:0] hi_q,
  output logic            aen,
  output logic            a_oe,
  output logic [LO_W-1:0] a_out,
  output logic            adstb,
  output logic            db_oe,
  output logic [HI_W-1:0] db_out,
  output logic            xfer_go
);
  logic            aen_q;
  logic [LO_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aen_q <= 1'b0;
      lo_q  <= '0;
    end else begin
      aen_q <= svc_active;
      if (take) lo_q <= lo_in;
    end
  end

  assign aen     = aen_q;
  assign a_oe    = aen_q;
  assign a_out   = lo_q;
  assign adstb   = (phase == PH_UPD);
  assign db_oe   = (phase == PH_UPD);
  assign db_out  = db_oe ? hi_q : '0;
  assign xfer_go = (phase == PH_XFER);

  // R6: the low byte holds through an update clock
  a_r6_lo_hold_upd: assert property (@(posedge clk) disable iff (!rst_n)
    adstb |=> $stable(a_out));
  // R9: the strobe and the bus drive appear only while address enable is up
  a_r9_strobe_in_svc: assert property (@(posedge clk) disable iff (!rst_n)
    (adstb || db_oe) |-> aen);
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_addr_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LO_W   = 8,
  localparam int HI_W  = ADDR_W - LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              svc_active,
  input  logic              step_valid,
  output logic              step_ready,
  input  logic [ADDR_W-1:0] step_addr,
  output logic              aen,
  output logic              a_oe,
  output logic [LO_W-1:0]   a_out,
  output logic              adstb,
  output logic              db_oe,
  output logic [HI_W-1:0]   db_out,
  output logic              xfer_go
);
  phase_t          phase;
  logic            take;
  logic            need_upd;
  logic [HI_W-1:0] hi_q;

  assign step_ready = svc_active && (phase != PH_UPD);
  assign take       = step_valid && step_ready;

  dma_hi_track #(.HI_W(HI_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .svc_active(svc_active), .take(take),
    .hi_in(step_addr[ADDR_W-1:LO_W]), .hi_q(hi_q), .need_upd(need_upd)
  );

  dma_phase_ctl u_phase (
    .clk(clk), .rst_n(rst_n), .svc_active(svc_active), .take(take),
    .need_upd(need_upd), .phase(phase)
  );

  dma_pin_drive #(.LO_W(LO_W), .HI_W(HI_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .svc_active(svc_active), .take(take),
    .lo_in(step_addr[LO_W-1:0]), .phase(phase), .hi_q(hi_q),
    .aen(aen), .a_oe(a_oe), .a_out(a_out), .adstb(adstb), .db_oe(db_oe),
    .db_out(db_out), .xfer_go(xfer_go)
  );

  // R2: address enable follows the service flag by one clock
  a_r2_aen_on: assert property (@(posedge clk) disable iff (!rst_n)
    svc_active |=> aen);
  a_r2_released: assert property (@(posedge clk) disable iff (!rst_n)
    !svc_active |=> (!a_oe && !adstb && !db_oe && !xfer_go));
  // R3: a taken step yields an update or a transfer on the next clock
  a_r3_step_acts: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (adstb || xfer_go));
  // R4: a taken step with an unchanged high byte goes straight to transfer
  a_r4_skip_upd: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !need_upd) |=> (xfer_go && !adstb));
  // R1: reset state
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!aen && !adstb && !db_oe && !xfer_go);
    end
  end
endmodule

// File: tb/dma_addr_seq_test.sv
`timescale 1ns/1ps
module dma_addr_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        svc = 1'b0;
  logic        vld = 1'b0;
  logic [15:0] addr = '0;
  logic        rdy, aen, a_oe, adstb, db_oe, xfer_go;
  logic [7:0]  a_out, db_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    bit       aen;
    bit       stb;
    bit [7:0] db;
    bit [7:0] lo;
    bit       go;
    bit       chk_lo;
    string    tag;
  } exp_t;
  exp_t q[$];

  bit       have_hi = 1'b0;
  bit [7:0] last_hi = '0;
  bit [7:0] cur_lo = '0;
  bit       in_upd = 1'b0;

  always #4 clk = ~clk;

  dma_addr_seq uut (
    .clk(clk), .rst_n(rst_n), .svc_active(svc), .step_valid(vld),
    .step_ready(rdy), .step_addr(addr), .aen(aen), .a_oe(a_oe),
    .a_out(a_out), .adstb(adstb), .db_oe(db_oe), .db_out(db_out),
    .xfer_go(xfer_go)
  );

  // monitor: compare one expected slot per rising edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      bit ok;
      e = q.pop_front();
      ok = (aen == e.aen) && (a_oe == e.aen) && (adstb == e.stb) &&
           (db_oe == e.stb) && (xfer_go == e.go) &&
           (!e.stb || db_out == e.db) && (!e.chk_lo || a_out == e.lo);
      total++;
      if (!ok) begin
        bad++;
        $display("FAIL %s: aen=%0b oe=%0b stb=%0b dboe=%0b db=%h lo=%h go=%0b exp aen=%0b stb=%0b db=%h lo=%h go=%0b",
                 e.tag, aen, a_oe, adstb, db_oe, db_out, a_out, xfer_go,
                 e.aen, e.stb, e.db, e.lo, e.go);
      end
    end
  end

  // driver: apply one clock of stimulus and queue the result due next edge
  task automatic step(input bit s, input bit v, input logic [15:0] ad, input string tag);
    exp_t e;
    bit r, acc;
    @(negedge clk);
    svc = s; vld = v; addr = ad;
    #1;
    r = s && !in_upd;
    total++;
    if (rdy !== r) begin
      bad++;
      $display("FAIL R6 (%s): step_ready=%0b expected %0b", tag, rdy, r);
    end
    acc = v && r;
    e.aen = s; e.stb = 1'b0; e.db = '0; e.go = 1'b0; e.chk_lo = s; e.tag = tag;
    if (!s) have_hi = 1'b0;
    else if (in_upd) e.go = 1'b1;
    else if (acc) begin
      cur_lo = ad[7:0];
      if (!have_hi || ad[15:8] != last_hi) begin
        e.stb = 1'b1; e.db = ad[15:8];
      end else e.go = 1'b1;
      last_hi = ad[15:8];
      have_hi = 1'b1;
    end
    e.lo = cur_lo;
    in_upd = e.stb;
    q.push_back(e);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          bad++; total++;
          $display("FAIL watchdog: run did not end, expected completion");
          $display("  test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none

    // R1: reset state
    #10;
    total++;
    if (aen || a_oe || adstb || db_oe || xfer_go || a_out != 8'h00) begin
      bad++;
      $display("FAIL R1: aen=%0b oe=%0b stb=%0b dboe=%0b go=%0b lo=%h expected all 0",
               aen, a_oe, adstb, db_oe, xfer_go, a_out);
    end
    @(negedge clk); rst_n = 1'b1;

    step(0, 1, 16'h5555, "R2");          // not ready while idle
    step(0, 0, 16'h0000, "R2");
    step(1, 1, 16'h1234, "R3");          // first step -> update
    step(1, 1, 16'h1235, "R6");          // offered during update, refused
    step(1, 1, 16'h1235, "R4");          // same page, no update
    step(1, 1, 16'h1236, "R4");
    step(1, 0, 16'h0000, "R7");          // no step
    step(1, 0, 16'h0000, "R7");
    step(1, 1, 16'h12FF, "R4");
    step(1, 1, 16'h1300, "R5");          // page crossing
    step(1, 0, 16'h0000, "R3");
    step(1, 1, 16'h1301, "R4");
    step(1, 1, 16'h1300, "R4");
    step(1, 1, 16'h12FF, "R5");          // decrement across page
    step(1, 0, 16'h0000, "R9");
    step(0, 0, 16'h0000, "R2");          // service ends
    step(0, 1, 16'h12AA, "R2");
    step(1, 1, 16'h12AB, "R8");          // same page, new service
    step(1, 0, 16'h0000, "R8");
    step(1, 1, 16'h12AC, "R4");
    step(1, 1, 16'hABCD, "R5");
    step(0, 0, 16'h0000, "R2");          // drop during update
    step(0, 0, 16'h0000, "R2");
    step(1, 1, 16'h0001, "R3");
    step(1, 1, 16'h0002, "R6");
    step(1, 1, 16'h0002, "R4");
    step(0, 0, 16'h0000, "R2");
    step(0, 0, 16'h0000, "R2");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule